// File: doc/BRIEF.md
# Gap Stretching Pulse Reshaper

This block stands in for a unit that reshapes a burst of pulses. It watches a single input line, measures how long each high pulse lasts in units of a 1 µs tick, and stores each width in a small queue. A long quiet period on the input marks the end of a burst. The block then plays the burst back on its output. Each pulse keeps its measured width. Every gap between pulses becomes a fixed, longer gap whatever the input gap was. The final pulse is followed by a gap and then a trailing segment. The whole output is inverted, so a pulse shows as a low level and idle shows as high.

Because playback only starts once the burst is complete, the output trails the input by the burst length plus the end-of-burst timeout. Two state machines do the work. The meter has states `MS_IDLE`, `MS_HIGH` and `MS_LOW`, with these transitions:
- IDLE→HIGH on a rising input.
- HIGH→LOW on a falling input, which pushes the width.
- LOW→HIGH on the next rising input.
- LOW→IDLE once the low time exceeds the end limit, which closes the burst.

The player has states `RP_IDLE`, `RP_MARK`, `RP_SPACE` and `RP_TAIL`, with these transitions:
- IDLE→MARK when a complete burst is ready, popping a width.
- MARK→SPACE when the width has elapsed.
- SPACE→MARK after the gap if the pulse just played was not the last one, popping the next width.
- SPACE→TAIL after the gap if it was the last one.
- TAIL→IDLE when the trailing segment ends, which retires the burst.

Top module: `gap_stretch_reshaper`

## Requirements
- R1: After reset, and whenever no burst is being played, `pulse_out_n` is 1. `overflow_err` is 0 after reset.
- R2: Each input high pulse is counted in `tick_us` strobes. It is replayed as a low level on `pulse_out_n` lasting the same number of ticks, within ±1 tick.
- R3: Between two replayed pulses of one burst, `pulse_out_n` is high for exactly `GAP_TICKS` ticks, whatever the input gap was.
- R4: After the last replayed pulse of a burst, `pulse_out_n` is high for `GAP_TICKS` ticks, then low for `TRAIL_TICKS` ticks, then returns to the idle high level. This also applies to a burst of one pulse.
- R5: A burst ends only when the input stays low for more than `END_TICKS` ticks. A shorter low period, however long its input gap, keeps the following pulse in the same burst.
- R6: Playback of a burst starts only after that burst has ended. While the first burst is still arriving, `pulse_out_n` stays high.
- R7: The queue holds `DEPTH` widths. Pulses that arrive while the queue is full are dropped and never replayed. The pulses already stored are replayed in arrival order.
- R8: `overflow_err` goes to 1 when a pulse is dropped. It stays 1 until reset.
- R9: All durations are counted only on cycles where `tick_us` is 1. When the tick arrives every second clock, every input and output duration in clock cycles scales by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle strobe marking each 1 µs time unit |
| pulse_in | input | 1 | Input pulse line, idle low |
| pulse_out_n | output | 1 | Reshaped, inverted output line, idle high |
| overflow_err | output | 1 | Sticky flag: a pulse was dropped because the queue was full |

## Verification
The assertions assume three things about the input:
- Every burst is separated from the next by more than the end-of-burst timeout.
- A burst that holds stored pulses is retired before the queue could hold pulses of two bursts in a way that would cross a last-pulse marker.
- `tick_us` keeps arriving, so that playback finishes.

The stimulus keeps to these assumptions. After each burst, it waits until every expected output segment has been observed before it sends the next burst. It changes the tick rate only between bursts, and it sends the overflow burst into an empty queue, so that exactly `DEPTH` pulses are kept.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_HIGH,
        MS_LOW
    } meter_state_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_MARK,
        RP_SPACE,
        RP_TAIL
    } replay_state_e;

endpackage

// File: rtl/gsr_meter.sv
module gsr_meter #(
    parameter int CW        = 12,
    parameter int END_TICKS = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    output logic          push,
    output logic [CW-1:0] push_width,
    output logic          burst_end
);
    import gsr_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] END_LIM = CW'(END_TICKS);
    localparam logic [CW-1:0] ONE     = CW'(1);

    meter_state_e  state_q, state_d;
    logic          din_q;
    logic [CW-1:0] wcnt_q;
    logic [CW-1:0] lcnt_q;

    // one register stage on the raw input line
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d   = state_q;
        push      = 1'b0;
        burst_end = 1'b0;
        unique case (state_q)
            MS_IDLE: begin
                if (din_q) state_d = MS_HIGH;
            end
            MS_HIGH: begin
                if (!din_q) begin
                    push    = 1'b1;
                    state_d = MS_LOW;
                end
            end
            MS_LOW: begin
                if (din_q) begin
                    state_d = MS_HIGH;
                end else if (lcnt_q > END_LIM) begin
                    burst_end = 1'b1;
                    state_d   = MS_IDLE;
                end
            end
            default: state_d = MS_IDLE;
        endcase
    end

    assign push_width = (wcnt_q == '0) ? ONE : wcnt_q;

    // width and low-time counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            lcnt_q <= '0;
        end else begin
            if (state_q != MS_HIGH && state_d == MS_HIGH)
                wcnt_q <= tick ? ONE : '0;
            else if (state_q == MS_HIGH && tick && wcnt_q != CNT_MAX)
                wcnt_q <= wcnt_q + ONE;

            if (state_q != MS_LOW)
                lcnt_q <= '0;
            else if (tick && lcnt_q != CNT_MAX)
                lcnt_q <= lcnt_q + ONE;
        end
    end

endmodule

// File: rtl/gsr_fifo.sv
module gsr_fifo #(
    parameter int CW    = 12,
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CW-1:0]    push_width,
    input  logic             mark_last,
    input  logic             pop,
    output logic [CW-1:0]    head_width,
    output logic             head_last,
    output logic [CNT_W-1:0] count,
    output logic             accepted,
    output logic             dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0]    PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CW-1:0] wmem [DEPTH];
    logic          lmem [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q, prev_ptr;
    logic [CNT_W-1:0] count_q;

    assign accepted   = push && (count_q != FULL_CNT);
    assign dropped    = push && (count_q == FULL_CNT);
    assign head_width = wmem[rd_ptr_q];
    assign head_last  = lmem[rd_ptr_q];
    assign count      = count_q;
    assign prev_ptr   = (wr_ptr_q == '0) ? PTR_LAST : wr_ptr_q - PW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                wmem[i] <= '0;
                lmem[i] <= 1'b0;
            end
        end else begin
            if (accepted) begin
                wmem[wr_ptr_q] <= push_width;
                lmem[wr_ptr_q] <= 1'b0;
            end
            if (mark_last) lmem[prev_ptr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accepted) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PW'(1);
            if (pop)      rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + PW'(1);
            unique case ({accepted, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/gsr_replay.sv
module gsr_replay #(
    parameter int CW          = 12,
    parameter int GAP_TICKS   = 200,
    parameter int TRAIL_TICKS = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [CW-1:0] head_width,
    input  logic          head_last,
    output logic          pop,
    output logic          frame_done,
    output logic          line_active
);
    import gsr_pkg::*;

    localparam int MAXC = (GAP_TICKS > TRAIL_TICKS) ? GAP_TICKS : TRAIL_TICKS;
    localparam int MW   = $clog2(MAXC + 1);
    localparam int RW   = (CW > MW) ? CW : MW;
    localparam logic [RW-1:0] GAP_L   = RW'(GAP_TICKS);
    localparam logic [RW-1:0] TRAIL_L = RW'(TRAIL_TICKS);
    localparam logic [RW-1:0] ONE     = RW'(1);

    replay_state_e state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic          last_q, last_d;
    logic          tail_q, tail_d;
    logic          seg_done;

    assign seg_done = tick && (cnt_q <= ONE);

    // state register with its counter and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            cnt_q   <= '0;
            last_q  <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
            tail_q  <= tail_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        last_d     = last_q;
        tail_d     = tail_q;
        pop        = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            RP_IDLE: begin
                if (start) begin
                    pop     = 1'b1;
                    cnt_d   = RW'(head_width);
                    last_d  = head_last;
                    state_d = RP_MARK;
                end
            end
            RP_MARK: begin
                if (seg_done) begin
                    cnt_d   = GAP_L;
                    tail_d  = last_q;
                    state_d = RP_SPACE;
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            RP_SPACE: begin
                if (seg_done) begin
                    if (tail_q) begin
                        cnt_d   = TRAIL_L;
                        state_d = RP_TAIL;
                    end else begin
                        pop     = 1'b1;
                        cnt_d   = RW'(head_width);
                        last_d  = head_last;
                        state_d = RP_MARK;
                    end
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            RP_TAIL: begin
                if (seg_done) begin
                    frame_done = 1'b1;
                    tail_d     = 1'b0;
                    state_d    = RP_IDLE;
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: state_d = RP_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        line_active = (state_q == RP_MARK) || (state_q == RP_TAIL);
    end

endmodule

// File: rtl/gap_stretch_reshaper.sv
module gap_stretch_reshaper #(
    parameter int CW          = 12,
    parameter int DEPTH       = 8,
    parameter int GAP_TICKS   = 200,
    parameter int TRAIL_TICKS = 200,
    parameter int END_TICKS   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic pulse_in,
    output logic pulse_out_n,
    output logic overflow_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, burst_end, pop, frame_done, line_active;
    logic             accepted, dropped, mark_last, head_last;
    logic [CW-1:0]    push_width, head_width;
    logic [CNT_W-1:0] fifo_count;
    logic [CNT_W-1:0] burst_cnt_q;
    logic [CNT_W-1:0] bursts_ready;
    logic             err_q;

    gsr_meter #(.CW(CW), .END_TICKS(END_TICKS)) u_meter (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .din(pulse_in),
        .push(push), .push_width(push_width), .burst_end(burst_end)
    );

    gsr_fifo #(.CW(CW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_width(push_width),
        .mark_last(mark_last), .pop(pop), .head_width(head_width),
        .head_last(head_last), .count(fifo_count), .accepted(accepted),
        .dropped(dropped)
    );

    gsr_replay #(.CW(CW), .GAP_TICKS(GAP_TICKS), .TRAIL_TICKS(TRAIL_TICKS)) u_replay (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .start(bursts_ready != '0),
        .head_width(head_width), .head_last(head_last), .pop(pop),
        .frame_done(frame_done), .line_active(line_active)
    );

    assign mark_last = burst_end && (burst_cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_cnt_q  <= '0;
            bursts_ready <= '0;
            err_q        <= 1'b0;
        end else begin
            if (burst_end)     burst_cnt_q <= '0;
            else if (accepted) burst_cnt_q <= burst_cnt_q + CNT_W'(1);

            unique case ({mark_last, frame_done})
                2'b10:   bursts_ready <= bursts_ready + CNT_W'(1);
                2'b01:   bursts_ready <= bursts_ready - CNT_W'(1);
                default: bursts_ready <= bursts_ready;
            endcase

            if (dropped) err_q <= 1'b1;
        end
    end

    assign pulse_out_n  = ~line_active;
    assign overflow_err = err_q;

endmodule

// File: rtl/gsr_checker.sv
module gsr_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic [CNT_W-1:0] fifo_count,
    input logic [CNT_W-1:0] bursts_ready,
    input logic             overflow_err,
    input logic             pulse_out_n
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err); // R8

    AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_count == FULL_CNT) |=> (overflow_err && fifo_count == FULL_CNT)); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL_CNT); // R7

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fifo_count != '0); // R7

    AST_POP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> bursts_ready != '0); // R6

    AST_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bursts_ready == '0) |-> pulse_out_n); // R1

endmodule

bind gap_stretch_reshaper gsr_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .fifo_count(fifo_count), .bursts_ready(bursts_ready),
    .overflow_err(overflow_err), .pulse_out_n(pulse_out_n)
);

// File: tb/gap_stretch_reshaper_tb.sv
module gap_stretch_reshaper_tb;

    localparam int GAP   = 12;
    localparam int TRAIL = 9;
    localparam int ENDT  = 30;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic pulse_in = 1'b0;
    logic pulse_out_n;
    logic overflow_err;

    int n_checks = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tphase = 0;
    int cyc = 0;
    bit saw_low = 0;

    int    e_lvl[$];
    int    e_len[$];
    int    e_tol[$];
    string e_tag[$];

    int run_lvl = 1;
    int run_len = 0;

    always #2.5 clk = ~clk;

    gap_stretch_reshaper #(
        .CW(12), .DEPTH(DEPTH), .GAP_TICKS(GAP),
        .TRAIL_TICKS(TRAIL), .END_TICKS(ENDT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .pulse_in(pulse_in),
        .pulse_out_n(pulse_out_n), .overflow_err(overflow_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // tick generator, driven away from the active edge
    always @(negedge clk) begin
        tphase  = (tphase + 1 >= tick_div) ? 0 : tphase + 1;
        tick_us = (tphase == 0);
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    // monitor: measures output run lengths and pops the scoreboard
    task automatic close_run(input int lvl, input int len);
        if (e_lvl.size() == 0) begin
            if (lvl == 0) chk(1'b0, "R1 unexpected low run", len, 0);
        end else if (lvl == 1 && e_lvl[0] == 0) begin
            // idle high ahead of a burst: not compared
        end else begin
            int xl, xn, xt;
            string tg;
            xl = e_lvl.pop_front();
            xn = e_len.pop_front();
            xt = e_tol.pop_front();
            tg = e_tag.pop_front();
            chk(lvl == xl, {tg, " level"}, lvl, xl);
            chk((len >= xn - xt) && (len <= xn + xt), {tg, " length"}, len, xn);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            run_lvl = 1;
            run_len = 0;
        end else if (int'(pulse_out_n) == run_lvl) begin
            run_len++;
        end else begin
            close_run(run_lvl, run_len);
            run_lvl = int'(pulse_out_n);
            run_len = 1;
        end
    end

    // driver: pushes expected segments, then drives the input burst
    task automatic send_burst(input int n, input int w[12], input int g[12],
                              input int nkeep, input string ptag);
        int tol;
        tol = (tick_div == 1) ? 1 : tick_div + 1;
        for (int k = 0; k < nkeep; k++) begin
            e_lvl.push_back(0); e_len.push_back(w[k] * tick_div);
            e_tol.push_back(tol); e_tag.push_back(ptag);
            e_lvl.push_back(1); e_len.push_back(GAP * tick_div);
            e_tol.push_back(tol); e_tag.push_back((k < nkeep - 1) ? "R3 gap" : "R4 tail gap");
        end
        e_lvl.push_back(0); e_len.push_back(TRAIL * tick_div);
        e_tol.push_back(tol); e_tag.push_back("R4 trail");
        saw_low = 0;
        for (int k = 0; k < n; k++) begin
            pulse_in = 1'b1;
            for (int c = 0; c < w[k] * tick_div; c++) begin
                @(negedge clk);
                if (!pulse_out_n) saw_low = 1;
            end
            pulse_in = 1'b0;
            if (k < n - 1) begin
                for (int c = 0; c < g[k] * tick_div; c++) begin
                    @(negedge clk);
                    if (!pulse_out_n) saw_low = 1;
                end
            end
        end
    endtask

    task automatic wait_drain();
        while (e_lvl.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int wa[12];
        int ga[12];

        repeat (5) @(negedge clk);
        chk(pulse_out_n == 1'b1, "R1 reset output", int'(pulse_out_n), 1);
        chk(overflow_err == 1'b0, "R1 reset error flag", int'(overflow_err), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // six-pulse burst with short input gaps (R2, R3, R4, R6)
        wa = '{40, 55, 30, 62, 45, 50, 0, 0, 0, 0, 0, 0};
        ga = '{5, 5, 5, 5, 5, 5, 0, 0, 0, 0, 0, 0};
        send_burst(6, wa, ga, 6, "R2 pulse");
        chk(saw_low == 0, "R6 output idle while burst arrives", int'(saw_low), 0);
        chk(pulse_out_n == 1'b1, "R6 no playback before burst end", int'(pulse_out_n), 1);
        wait_drain();

        // intra-burst low of 25 ticks, below the end limit (R5)
        wa = '{20, 33, 27, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        ga = '{25, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_burst(3, wa, ga, 3, "R5 pulse");
        wait_drain();

        // single-pulse burst (R4)
        wa = '{17, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_burst(1, wa, ga, 1, "R4 single pulse");
        wait_drain();

        // slower tick, every second clock (R9)
        tick_div = 2;
        repeat (4) @(negedge clk);
        wa = '{20, 30, 25, 15, 0, 0, 0, 0, 0, 0, 0, 0};
        ga = '{5, 7, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_burst(4, wa, ga, 4, "R9 pulse");
        wait_drain();
        tick_div = 1;
        repeat (4) @(negedge clk);

        // overflow: ten pulses into an empty queue of eight (R7, R8)
        chk(overflow_err == 1'b0, "R8 flag clear before overflow", int'(overflow_err), 0);
        wa = '{10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 0, 0};
        ga = '{5, 5, 5, 5, 5, 5, 5, 5, 5, 0, 0, 0};
        send_burst(10, wa, ga, DEPTH, "R7 kept pulse");
        repeat (3) @(negedge clk);
        chk(overflow_err == 1'b1, "R8 flag set on drop", int'(overflow_err), 1);
        wait_drain();
        repeat (50) @(negedge clk);
        chk(overflow_err == 1'b1, "R8 flag sticky", int'(overflow_err), 1);
        chk(pulse_out_n == 1'b1, "R7 dropped pulses not replayed", int'(pulse_out_n), 1);

        // reset clears the flag (R8, R1)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(overflow_err == 1'b0, "R8 flag cleared by reset", int'(overflow_err), 0);
        chk(pulse_out_n == 1'b1, "R1 idle after reset", int'(pulse_out_n), 1);

        // normal operation after reset (R2, R3)
        wa = '{28, 36, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        ga = '{9, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        send_burst(2, wa, ga, 2, "R2 pulse after reset");
        wait_drain();

        chk(e_lvl.size() == 0, "R7 all expected segments seen", e_lvl.size(), 0);
        summary();
        $finish;
    end

endmodule